// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves the operand reference of one instruction. It takes a 3-bit addressing-mode code and the instruction's address field, then returns one of two things: the operand value itself, or the effective address where the operand lives. It handles five modes. Immediate returns the field as a value. Direct returns the field as an address. Indirect reads a pointer word from memory. Indexed adds the index register. Relative adds a signed offset to the program counter.

A request is made by pulsing `start_i` with the mode, the field, the current PC and the index register value. The unit answers with a one-cycle `done_o` pulse. In indirect mode it makes one extra memory read through its own read port before it answers. That read returns a full machine word, so the resulting address can reach the whole address space and is not limited to the field width.

For array walks, the index register can be post-incremented. The unit does not hold that register itself. It reports the incremented value together with a write strobe, and the register's owner stores it. Operand fetch, ALU work and write-back are handled by the surrounding logic.

Top module: `eaddr_unit`

## Requirements
- R1: After a synchronous active-low reset, `done_o`, `mem_req_o`, `err_o` and `idx_wr_o` are all 0.
- R2: Mode code 0 (immediate). `done_o` pulses one cycle after `start_i` is accepted. `result_o` is the field zero-extended to AW bits and `is_value_o` is 1. No memory request is made.
- R3: Mode code 1 (direct). `done_o` pulses one cycle after start. `result_o` is the field zero-extended and `is_value_o` is 0. No memory request is made.
- R4: Mode code 2 (indirect). `mem_req_o` rises one cycle after start, with `mem_addr_o` equal to the zero-extended field. Both hold steady until `mem_valid_i` is sampled high. In the cycle after that, `done_o` pulses with `result_o` equal to the full AW-bit `mem_rdata_i` word and `is_value_o` at 0.
- R5: Mode code 3 (indexed). `done_o` pulses one cycle after start. `result_o` is (zero-extended field + `idx_i`) modulo 2^AW.
- R6: Mode code 4 (relative). `done_o` pulses one cycle after start. `result_o` is (`pc_i` + sign-extended field) modulo 2^AW. The field is read as a two's-complement number.
- R7: In indexed mode with `post_inc_i` high, `idx_wr_o` pulses together with `done_o`, and `idx_next_o` equals (`idx_i` + 1) modulo 2^AW. In every other mode `post_inc_i` is ignored and `idx_wr_o` stays 0.
- R8: Mode codes 5, 6 and 7 are invalid. Each produces a `done_o` pulse one cycle after start, with `err_o` at 1, `result_o` at 0 and no memory request.
- R9: A `start_i` that arrives while an indirect read is still outstanding is ignored. No extra `done_o` appears, and `mem_addr_o` does not change.
- R10: `err_o` and `idx_wr_o` are high only in a cycle in which `done_o` is high. A new start presented during a `done_o` cycle is accepted and answered on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing-mode code |
| field_i | input | FW | Address field of the instruction |
| pc_i | input | AW | Current program counter |
| idx_i | input | AW | Current index register value |
| post_inc_i | input | 1 | Request index post-increment (indexed mode only) |
| mem_req_o | output | 1 | Pointer read request, held until accepted |
| mem_addr_o | output | AW | Pointer read address |
| mem_rdata_i | input | AW | Pointer read data |
| mem_valid_i | input | 1 | Read data valid |
| done_o | output | 1 | Result valid, one-cycle pulse |
| is_value_o | output | 1 | 1: result is the operand value; 0: result is an address |
| result_o | output | AW | Operand value or effective address |
| err_o | output | 1 | Invalid mode code |
| idx_wr_o | output | 1 | Index register write strobe |
| idx_next_o | output | AW | Incremented index value |

## Verification
A corrupted wait state shows up at the ports within one cycle, as a `mem_req_o` that is missing or stuck, or as a `done_o` pulse without a matching read. A wrongly latched result or extension shows up in the very `done_o` cycle as a bad `result_o`. The bench is built to expose these cases: a field with its top bit set in relative mode, sums that wrap past the top of the address range, a pointer word wider than the field, and a start that arrives in the middle of a read. Every output is compared against a behavioural model on every clock, so any divergence is caught in the cycle it first appears.

// File: rtl/eaddr_pkg.sv
// Shared addressing-mode codes for the effective address unit.
package eaddr_pkg;
    typedef enum logic [2:0] {
        MD_IMM = 3'd0,
        MD_DIR = 3'd1,
        MD_IND = 3'd2,
        MD_IDX = 3'd3,
        MD_REL = 3'd4
    } mode_e;
endpackage

// File: rtl/eaddr_calc.sv
// Combinational address arithmetic for every mode.
// Assumes FW <= AW. All sums wrap modulo 2^AW.
module eaddr_calc #(
    parameter int AW = 16,
    parameter int FW = 12
) (
    input  logic [2:0]    mode,
    input  logic [FW-1:0] field,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] ea,
    output logic          is_val,
    output logic          mode_ok,
    output logic          needs_mem
);
    import eaddr_pkg::*;
    localparam int EXT = AW - FW;

    logic [AW-1:0] zext, sext;

    // Field extension, chosen by the width difference
    generate
        if (EXT > 0) begin : g_ext
            assign zext = {{EXT{1'b0}}, field};
            assign sext = {{EXT{field[FW-1]}}, field};
        end else begin : g_same
            assign zext = field;
            assign sext = field;
        end
    endgenerate

    // Mode decode and address sum
    always_comb begin
        ea        = '0;
        is_val    = 1'b0;
        mode_ok   = 1'b1;
        needs_mem = 1'b0;
        case (mode)
            MD_IMM: begin ea = zext; is_val = 1'b1; end
            MD_DIR: ea = zext;
            MD_IND: begin ea = zext; needs_mem = 1'b1; end
            MD_IDX: ea = zext + idx;
            MD_REL: ea = pc + sext;
            default: mode_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/eaddr_idx_step.sv
// Next index value for the post-increment. Assumes the owner of the
// index register stores the value only when the write strobe is set.
module eaddr_idx_step #(
    parameter int AW   = 16,
    parameter int STEP = 1
) (
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] idx_plus
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Wrapping increment
    assign idx_plus = idx + STEP_V;
endmodule

// File: rtl/eaddr_ctrl.sv
// Handshake sequencer. An indirect request waits for the read and
// ignores new starts meanwhile; every other mode answers one cycle
// after start. Done, error and index-write are single-cycle pulses.
module eaddr_ctrl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ea,
    input  logic          is_val,
    input  logic          mode_ok,
    input  logic          needs_mem,
    input  logic          inc_req,
    input  logic [AW-1:0] idx_plus,
    input  logic [AW-1:0] rdata,
    input  logic          rvalid,
    output logic          req,
    output logic [AW-1:0] addr,
    output logic          done,
    output logic          res_is_val,
    output logic [AW-1:0] res,
    output logic          err,
    output logic          iw,
    output logic [AW-1:0] inext
);
    typedef enum logic {S_IDLE, S_WAIT} state_e;
    state_e state;

    // Sequencing and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            req        <= 1'b0;
            addr       <= '0;
            done       <= 1'b0;
            res_is_val <= 1'b0;
            res        <= '0;
            err        <= 1'b0;
            iw         <= 1'b0;
            inext      <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            iw   <= 1'b0;
            case (state)
                S_IDLE: if (start) begin
                    if (needs_mem) begin
                        state <= S_WAIT;
                        req   <= 1'b1;
                        addr  <= ea;
                    end else begin
                        done       <= 1'b1;
                        res        <= mode_ok ? ea : '0;
                        res_is_val <= is_val & mode_ok;
                        err        <= ~mode_ok;
                        iw         <= inc_req;
                        inext      <= idx_plus;
                    end
                end
                S_WAIT: if (rvalid) begin
                    state      <= S_IDLE;
                    req        <= 1'b0;
                    done       <= 1'b1;
                    res        <= rdata;
                    res_is_val <= 1'b0;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R4: request and its address hold until data arrives
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rvalid) |=> (req && $stable(addr)));
    // R4: no request outstanding in a done cycle
    p_no_req_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req);
    // R2: a start with no read needed is answered next cycle
    p_quick_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !needs_mem) |=> done);
    // R9: start during an outstanding read gives no answer
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !rvalid && start) |=> !done);
    // R10: error only with done
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R7: index write only with done
    p_iw_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        iw |-> done);
endmodule

// File: rtl/eaddr_unit.sv
// Top level: computes the effective address or operand value for one
// instruction. Assumes field width FW <= address/word width AW.
module eaddr_unit #(
    parameter int AW = 16,
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    mode_i,
    input  logic [FW-1:0] field_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] idx_i,
    input  logic          post_inc_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [AW-1:0] mem_rdata_i,
    input  logic          mem_valid_i,
    output logic          done_o,
    output logic          is_value_o,
    output logic [AW-1:0] result_o,
    output logic          err_o,
    output logic          idx_wr_o,
    output logic [AW-1:0] idx_next_o
);
    import eaddr_pkg::*;

    logic [AW-1:0] ea, idx_plus;
    logic          is_val, mode_ok, needs_mem, inc_req;

    // Post-increment applies to indexed mode only
    assign inc_req = post_inc_i && (mode_i == MD_IDX);

    eaddr_calc #(.AW(AW), .FW(FW)) u_calc (
        .mode(mode_i), .field(field_i), .pc(pc_i), .idx(idx_i),
        .ea(ea), .is_val(is_val), .mode_ok(mode_ok), .needs_mem(needs_mem)
    );

    eaddr_idx_step #(.AW(AW), .STEP(1)) u_step (
        .idx(idx_i), .idx_plus(idx_plus)
    );

    eaddr_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start_i), .ea(ea),
        .is_val(is_val), .mode_ok(mode_ok), .needs_mem(needs_mem),
        .inc_req(inc_req), .idx_plus(idx_plus),
        .rdata(mem_rdata_i), .rvalid(mem_valid_i),
        .req(mem_req_o), .addr(mem_addr_o), .done(done_o),
        .res_is_val(is_value_o), .res(result_o), .err(err_o),
        .iw(idx_wr_o), .inext(idx_next_o)
    );
endmodule

// File: tb/eaddr_unit_bench.sv
module eaddr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [11:0] field = '0;
    logic [15:0] pc = '0, idx = '0, mem_rdata = '0;
    logic        post_inc = 1'b0, mem_valid = 1'b0;
    logic        mem_req, done, is_value, err, idx_wr;
    logic [15:0] mem_addr, result, idx_next;

    int checks = 0, failures = 0, cycles = 0;
    string cur_tag = "R1";
    bit finished = 0;

    always #2.5 clk = ~clk;

    eaddr_unit u_eaddr_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .field_i(field), .pc_i(pc), .idx_i(idx), .post_inc_i(post_inc),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .mem_valid_i(mem_valid), .done_o(done), .is_value_o(is_value),
        .result_o(result), .err_o(err), .idx_wr_o(idx_wr), .idx_next_o(idx_next)
    );

    // Behavioural reference model of the requirements
    bit          busy;
    logic        e_done, e_req, e_isv, e_err, e_iw;
    logic [15:0] e_addr, e_res, e_inext;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; e_done = 0; e_req = 0; e_isv = 0; e_err = 0; e_iw = 0;
            e_addr = 0; e_res = 0; e_inext = 0;
        end else begin
            e_done = 0; e_err = 0; e_iw = 0;
            if (busy) begin
                if (mem_valid) begin
                    busy = 0; e_req = 0; e_done = 1; e_res = mem_rdata; e_isv = 0;
                end
            end else if (start) begin
                if (mode == 3'd2) begin
                    busy = 1; e_req = 1; e_addr = {4'h0, field};
                end else begin
                    e_done = 1; e_isv = 0; e_inext = idx + 16'd1;
                    e_iw = (mode == 3'd3) && post_inc;
                    case (mode)
                        3'd0: begin e_res = {4'h0, field}; e_isv = 1; end
                        3'd1: e_res = {4'h0, field};
                        3'd3: e_res = {4'h0, field} + idx;
                        3'd4: e_res = pc + {{4{field[11]}}, field};
                        default: begin e_res = 0; e_err = 1; end
                    endcase
                end
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison, away from the active edge
    always @(posedge clk) begin
        #1;
        if (!finished) begin
            chk(cur_tag, "done", {15'd0, done}, {15'd0, e_done});
            chk(cur_tag, "mem_req", {15'd0, mem_req}, {15'd0, e_req});
            chk(cur_tag == "R8" ? "R8" : "R10", "err", {15'd0, err}, {15'd0, e_err});
            chk(cur_tag == "R7" ? "R7" : "R10", "idx_wr", {15'd0, idx_wr}, {15'd0, e_iw});
            if (e_req) chk(cur_tag, "mem_addr", mem_addr, e_addr);
            if (e_done) begin
                chk(cur_tag, "result", result, e_res);
                chk(cur_tag, "is_value", {15'd0, is_value}, {15'd0, e_isv});
            end
            if (e_iw) chk("R7", "idx_next", idx_next, e_inext);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic op(input logic [2:0] md, input logic [11:0] f,
                      input logic [15:0] p, input logic [15:0] ix,
                      input logic pi, input int lat, input logic [15:0] rd,
                      input bit poke, input string tag);
        @(negedge clk);
        cur_tag = tag;
        start = 1; mode = md; field = f; pc = p; idx = ix; post_inc = pi;
        @(negedge clk);
        start = 0;
        if (md == 3'd2) begin
            for (int i = 0; i < lat; i++) begin
                if (poke && i == 0) begin start = 1; mode = 3'd0; field = 12'h555; end
                @(negedge clk);
                start = 0;
            end
            mem_rdata = rd; mem_valid = 1;
            @(negedge clk);
            mem_valid = 0;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;                                              // R1 checked per clock
        @(negedge clk);
        op(3'd0, 12'hABC, 16'h0, 16'h0, 0, 0, 0, 0, "R2");      // R2 immediate
        op(3'd0, 12'hABC, 16'h0, 16'h1234, 1, 0, 0, 0, "R7");   // R7 ignored outside indexed
        op(3'd1, 12'h123, 16'h0, 16'h0, 0, 0, 0, 0, "R3");      // R3 direct
        op(3'd2, 12'h040, 16'h0, 16'h0, 0, 0, 16'hF00D, 0, "R4"); // R4 zero wait
        op(3'd2, 12'hFFF, 16'h0, 16'h0, 0, 3, 16'h8001, 0, "R4"); // R4 three waits
        op(3'd3, 12'hFFF, 16'h0, 16'hF005, 0, 0, 0, 0, "R5");   // R5 wrap
        op(3'd3, 12'h010, 16'h0, 16'h0200, 0, 0, 0, 0, "R5");
        op(3'd4, 12'h800, 16'h0100, 16'h0, 0, 0, 0, 0, "R6");   // R6 negative offset
        op(3'd4, 12'h7FF, 16'hFFFF, 16'h0, 0, 0, 0, 0, "R6");   // R6 wrap
        op(3'd3, 12'h002, 16'h0, 16'hFFFF, 1, 0, 0, 0, "R7");   // R7 increment wraps
        op(3'd3, 12'h002, 16'h0, 16'h0041, 1, 0, 0, 0, "R7");
        op(3'd5, 12'h321, 16'h0, 16'h0, 0, 0, 0, 0, "R8");      // R8 invalid
        op(3'd7, 12'h321, 16'h0, 16'h0, 1, 0, 0, 0, "R8");
        op(3'd2, 12'h0AA, 16'h0, 16'h0, 0, 2, 16'h1357, 1, "R9"); // R9 start while busy
        // R10: start presented during a done cycle is taken next
        @(negedge clk);
        cur_tag = "R10";
        start = 1; mode = 3'd0; field = 12'h00F;
        @(negedge clk);
        mode = 3'd1; field = 12'h0F0;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule